// File: doc/BRIEF.md
# Multiplexed System Bus Controller (Processor Side)

This block connects a processor's internal read and write requests to a shared 32-bit multiplexed address/data bus. It also carries a 5-bit command field, one even-parity bit for each byte lane and one even-parity bit for the command. Every processor transfer begins with an address cycle, followed by one or more data cycles. A single transfer moves one word with 1 to 4 significant bytes. A block transfer moves 2 or 4 words.

The processor drives the bus only while it owns it. For a read, the controller hands the bus to the external agent after the address cycle, and the agent returns the data words. The external agent can request the bus itself to post a one-word write, which the controller delivers as an interrupt word.

The controller samples all bus inputs on the falling clock edge and updates its outputs on the rising edge. It checks parity on every received cycle. A mismatch raises a sticky error flag, and the received data is still delivered.

Top module: `sysbus_ctrl`

## Requirements
- R1: After reset, nothing is driven onto the bus: `ad_oe`, `cmd_oe`, `cpu_owner`, `cpu_valid`, `cpu_req`, `ext_grant` and `par_err` are 0, and `req_ready` is 1.
- R2: An accepted request produces one address cycle with these outputs:
  - `ad_o` equals the request address.
  - `cpu_owner`, `cpu_valid`, `ad_oe` and `cmd_oe` are 1.
  - `cmd_o` is {0, write, block, size}. For a single transfer, size is the byte count minus one. For a block, size is 00 for 2 words and 01 for 4 words.
- R3: A write follows its address cycle with back-to-back data cycles, one word for a single transfer and 2 or 4 words for a block. Word i comes from `req_wdata[32i+31:32i]`. `cmd_o` is {1, 01, last, 0}, where last is set only on the final word.
- R4: While the processor drives, each `adpar_o[k]` makes byte lane k of `ad_o` even, and `cmdpar_o` makes `cmd_o` even.
- R5: While a request is pending (`cpu_req` high), no address cycle starts unless `ext_ready` was high in the preceding cycle.
- R6: A read address cycle is followed by one idle cycle, then `ext_grant` rises. Each received cycle with `ext_valid` high and command {1, 00, x, x} is returned on `rd_data` with `rd_valid` two edges later. `rd_last` is set on the final word, and the grant then drops.
- R7: A sampled `ext_req` in the idle state gives one idle cycle, then `ext_grant`. A received cycle with command 11010 then pulses `intr_valid`, with the word on `intr_data`.
- R8: When `ext_req` and a pending request with `ext_ready` high are sampled together, the external request is served first. The processor's address cycle follows right after the interrupt word.
- R9: A received cycle with bad lane or command parity sets `par_err` until reset. `par_err_data` holds that cycle's type bit (1 for a data cycle). The data is still delivered.
- R10: The processor never drives while `ext_grant` is high, and at least one cycle with neither side granted separates the two.
- R11: During a read, a received cycle whose command is not a read data cycle produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | 1 | 1 = block transfer |
| req_long | input | 1 | Block length: 1 = 4 words, 0 = 2 words |
| req_bytes | input | 2 | Single transfer byte count minus one |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 128 | Write words, word i in bits 32i+31:32i |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 32 | Read word |
| rd_last | output | 1 | Final word of the read |
| intr_valid | output | 1 | External write (interrupt) word pulse |
| intr_data | output | 32 | External write word |
| par_err | output | 1 | Sticky parity error |
| par_err_data | output | 1 | Type of the failing cycle (1 = data) |
| ad_o | output | 32 | Address/data bus out |
| ad_i | input | 32 | Address/data bus in |
| ad_oe | output | 1 | Address/data and lane parity drive enable |
| adpar_o | output | 4 | Lane parity out |
| adpar_i | input | 4 | Lane parity in |
| cmd_o | output | 5 | Command out |
| cmd_i | input | 5 | Command in |
| cmd_oe | output | 1 | Command and command parity drive enable |
| cmdpar_o | output | 1 | Command parity out |
| cmdpar_i | input | 1 | Command parity in |
| cpu_req | output | 1 | Processor wants the bus |
| ext_req | input | 1 | External agent wants the bus |
| cpu_owner | output | 1 | Processor holds master status |
| cpu_valid | output | 1 | Processor-driven bus content valid |
| ext_valid | input | 1 | Agent-driven bus content valid |
| ext_ready | input | 1 | Agent can accept a processor request |
| ext_grant | output | 1 | External agent may drive the bus |

## Verification
Two decisions can fall in the same falling-edge sample: the external agent's bus request, and the issue of a pending processor request whose ready input is high. The bench holds a request back with `ext_ready` low, then raises `ext_ready` and `ext_req` in the same cycle. It judges the outcome by ports alone. First it expects the idle turnaround, the grant and the interrupt word while `cpu_req` stays high. Then it expects the processor address cycle on the very next edge. A second overlap, parity failure together with read data delivery, is provoked by corrupting one lane of a block read word, and the bench requires both the word and the sticky flag.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
  localparam int CMD_W = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WDATA, S_TURN_R, S_RWAIT, S_TURN_E, S_EXT
  } bus_state_t;

  localparam logic [1:0] K_READ  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_EXTW  = 2'b10;
endpackage

// File: rtl/sb_parity.sv
module sb_parity #(
  parameter int DW = 32,
  localparam int LN = DW / 8
) (
  input  logic [DW-1:0] d,
  output logic [LN-1:0] p
);
  for (genvar k = 0; k < LN; k++) begin : g_lane
    assign p[k] = ^d[8*k +: 8];
  end
endmodule

// File: rtl/sb_insample.sv
module sb_insample #(
  parameter int DW = 32,
  parameter int CW = 5,
  localparam int LN = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ad_i,
  input  logic [LN-1:0] adpar_i,
  input  logic [CW-1:0] cmd_i,
  input  logic          cmdpar_i,
  input  logic          ext_valid,
  input  logic          ext_req,
  input  logic          ext_ready,
  output logic [DW-1:0] ad_s,
  output logic [LN-1:0] adpar_s,
  output logic [CW-1:0] cmd_s,
  output logic          cmdpar_s,
  output logic          valid_s,
  output logic          req_s,
  output logic          ready_s
);
  always_ff @(negedge clk) begin
    if (rst) begin
      ad_s     <= '0;
      adpar_s  <= '0;
      cmd_s    <= '0;
      cmdpar_s <= 1'b0;
      valid_s  <= 1'b0;
      req_s    <= 1'b0;
      ready_s  <= 1'b0;
    end else begin
      ad_s     <= ad_i;
      adpar_s  <= adpar_i;
      cmd_s    <= cmd_i;
      cmdpar_s <= cmdpar_i;
      valid_s  <= ext_valid;
      req_s    <= ext_req;
      ready_s  <= ext_ready;
    end
  end
endmodule

// File: rtl/sb_seq.sv
module sb_seq
  import sysbus_pkg::*;
#(
  parameter int DW   = 32,
  parameter int MAXW = 4,
  localparam int CNT_W = $clog2(MAXW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_block,
  input  logic               req_long,
  input  logic [1:0]         req_bytes,
  input  logic [DW-1:0]      req_addr,
  input  logic [MAXW*DW-1:0] req_wdata,
  input  logic               req_s,
  input  logic               ready_s,
  input  logic               valid_s,
  input  logic [DW-1:0]      ad_s,
  input  logic [2:0]         kind_s,
  input  logic               rx_bad,
  output logic               req_ready,
  output logic               cpu_req,
  output logic               cpu_owner,
  output logic               ext_grant,
  output logic [DW-1:0]      ad_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               rd_last,
  output logic               intr_valid,
  output logic [DW-1:0]      intr_data,
  output logic               par_err,
  output logic               par_err_data
);
  bus_state_t         st;
  logic               pend_q, wr_q, blk_q, long_q;
  logic [1:0]         bytes_q;
  logic [DW-1:0]      addr_q;
  logic [MAXW*DW-1:0] wdat_q;
  logic [CNT_W-1:0]   idx_q, last_idx;
  logic               is_last, take_rd, take_ext;

  always_comb begin
    if (!blk_q)      last_idx = '0;
    else if (long_q) last_idx = CNT_W'(MAXW - 1);
    else             last_idx = CNT_W'(MAXW / 2 - 1);
  end

  assign is_last   = (idx_q == last_idx);
  assign take_rd   = valid_s && kind_s[2] && (kind_s[1:0] == K_READ);
  assign take_ext  = valid_s && kind_s[2] && (kind_s[1:0] == K_EXTW);
  assign req_ready = (st == S_IDLE) && !pend_q;
  assign cpu_req   = pend_q;
  assign cpu_owner = (st == S_ADDR) || (st == S_WDATA);
  assign ext_grant = (st == S_RWAIT) || (st == S_EXT);

  always_comb begin
    ad_o  = '0;
    cmd_o = '0;
    if (st == S_ADDR) begin
      ad_o  = addr_q;
      cmd_o = {1'b0, wr_q, blk_q, blk_q ? {1'b0, long_q} : bytes_q};
    end else if (st == S_WDATA) begin
      ad_o  = wdat_q[idx_q*DW +: DW];
      cmd_o = {1'b1, K_WRITE, is_last, 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      pend_q       <= 1'b0;
      wr_q         <= 1'b0;
      blk_q        <= 1'b0;
      long_q       <= 1'b0;
      bytes_q      <= '0;
      addr_q       <= '0;
      wdat_q       <= '0;
      idx_q        <= '0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_last      <= 1'b0;
      intr_valid   <= 1'b0;
      intr_data    <= '0;
      par_err      <= 1'b0;
      par_err_data <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      rd_last    <= 1'b0;
      intr_valid <= 1'b0;
      if (req_valid && req_ready) begin
        pend_q  <= 1'b1;
        wr_q    <= req_write;
        blk_q   <= req_block;
        long_q  <= req_long;
        bytes_q <= req_bytes;
        addr_q  <= req_addr;
        wdat_q  <= req_wdata;
      end
      case (st)
        S_IDLE: begin
          if (req_s) st <= S_TURN_E;
          else if (pend_q && ready_s) begin
            st     <= S_ADDR;
            pend_q <= 1'b0;
            idx_q  <= '0;
          end
        end
        S_ADDR:   st <= wr_q ? S_WDATA : S_TURN_R;
        S_WDATA: begin
          if (is_last) st <= S_IDLE;
          else         idx_q <= idx_q + 1'b1;
        end
        S_TURN_R: st <= S_RWAIT;
        S_RWAIT: begin
          if (take_rd) begin
            rd_valid <= 1'b1;
            rd_data  <= ad_s;
            rd_last  <= is_last;
            if (is_last) st <= S_IDLE;
            else         idx_q <= idx_q + 1'b1;
          end
        end
        S_TURN_E: st <= S_EXT;
        S_EXT: begin
          if (take_ext) begin
            intr_valid <= 1'b1;
            intr_data  <= ad_s;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (ext_grant && valid_s && rx_bad && !par_err) begin
        par_err      <= 1'b1;
        par_err_data <= kind_s[2];
      end
    end
  end
endmodule

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
  import sysbus_pkg::*;
#(
  parameter int DW   = 32,
  parameter int MAXW = 4,
  localparam int LN  = DW / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_block,
  input  logic               req_long,
  input  logic [1:0]         req_bytes,
  input  logic [DW-1:0]      req_addr,
  input  logic [MAXW*DW-1:0] req_wdata,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               rd_last,
  output logic               intr_valid,
  output logic [DW-1:0]      intr_data,
  output logic               par_err,
  output logic               par_err_data,
  output logic [DW-1:0]      ad_o,
  input  logic [DW-1:0]      ad_i,
  output logic               ad_oe,
  output logic [LN-1:0]      adpar_o,
  input  logic [LN-1:0]      adpar_i,
  output logic [CMD_W-1:0]   cmd_o,
  input  logic [CMD_W-1:0]   cmd_i,
  output logic               cmd_oe,
  output logic               cmdpar_o,
  input  logic               cmdpar_i,
  output logic               cpu_req,
  input  logic               ext_req,
  output logic               cpu_owner,
  output logic               cpu_valid,
  input  logic               ext_valid,
  input  logic               ext_ready,
  output logic               ext_grant
);
  logic [DW-1:0]    ad_s;
  logic [LN-1:0]    adpar_s, rx_lane;
  logic [CMD_W-1:0] cmd_s;
  logic             cmdpar_s, valid_s, req_s, ready_s, rx_bad;

  sb_insample #(.DW(DW), .CW(CMD_W)) u_in (
    .clk(clk), .rst(rst), .ad_i(ad_i), .adpar_i(adpar_i), .cmd_i(cmd_i),
    .cmdpar_i(cmdpar_i), .ext_valid(ext_valid), .ext_req(ext_req),
    .ext_ready(ext_ready), .ad_s(ad_s), .adpar_s(adpar_s), .cmd_s(cmd_s),
    .cmdpar_s(cmdpar_s), .valid_s(valid_s), .req_s(req_s), .ready_s(ready_s)
  );

  sb_parity #(.DW(DW)) u_rxpar (.d(ad_s), .p(rx_lane));
  sb_parity #(.DW(DW)) u_txpar (.d(ad_o), .p(adpar_o));

  assign rx_bad    = (|(rx_lane ^ adpar_s)) || ((^cmd_s) != cmdpar_s);
  assign cmdpar_o  = ^cmd_o;
  assign ad_oe     = cpu_owner;
  assign cmd_oe    = cpu_owner;
  assign cpu_valid = cpu_owner;

  sb_seq #(.DW(DW), .MAXW(MAXW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_block(req_block), .req_long(req_long), .req_bytes(req_bytes),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_s(req_s),
    .ready_s(ready_s), .valid_s(valid_s), .ad_s(ad_s),
    .kind_s(cmd_s[CMD_W-1:CMD_W-3]), .rx_bad(rx_bad),
    .req_ready(req_ready), .cpu_req(cpu_req), .cpu_owner(cpu_owner),
    .ext_grant(ext_grant), .ad_o(ad_o), .cmd_o(cmd_o),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .intr_valid(intr_valid), .intr_data(intr_data),
    .par_err(par_err), .par_err_data(par_err_data)
  );
endmodule

// File: rtl/sysbus_ctrl_chk.sv
module sysbus_ctrl_chk #(
  parameter int DW = 32,
  localparam int LN = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ad_oe,
  input logic          cmd_oe,
  input logic          ext_grant,
  input logic [DW-1:0] ad_o,
  input logic [LN-1:0] adpar_o,
  input logic [4:0]    cmd_o,
  input logic          cmdpar_o,
  input logic          cpu_valid,
  input logic          ext_ready,
  input logic          par_err,
  input logic          rd_valid,
  input logic          rd_last
);
  p_no_drive_in_grant_r10: assert property (@(posedge clk) disable iff (rst)
    !(ad_oe && ext_grant));

  p_turn_to_ext_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_grant) |-> !$past(ad_oe));

  p_turn_to_cpu_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> !$past(ext_grant));

  for (genvar k = 0; k < LN; k++) begin : g_lane_chk
    p_lane_even_r4: assert property (@(posedge clk) disable iff (rst)
      ad_oe |-> (^{ad_o[8*k +: 8], adpar_o[k]}) == 1'b0);
  end

  p_cmd_even_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> (^{cmd_o, cmdpar_o}) == 1'b0);

  p_ready_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cmd_o[4]) |-> $past(ext_ready));

  p_addr_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_valid) |-> !cmd_o[4]);

  p_sticky_err_r9: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  p_last_with_data_r6: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);
endmodule

bind sysbus_ctrl sysbus_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ad_oe(ad_oe), .cmd_oe(cmd_oe), .ext_grant(ext_grant),
  .ad_o(ad_o), .adpar_o(adpar_o), .cmd_o(cmd_o), .cmdpar_o(cmdpar_o),
  .cpu_valid(cpu_valid), .ext_ready(ext_ready), .par_err(par_err),
  .rd_valid(rd_valid), .rd_last(rd_last)
);

// File: tb/sysbus_ctrl_test.sv
module sysbus_ctrl_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0, req_block = 1'b0, req_long = 1'b0;
  logic [1:0]   req_bytes = '0;
  logic [31:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic         req_ready, rd_valid, rd_last, intr_valid, par_err, par_err_data;
  logic [31:0]  rd_data, intr_data, ad_o;
  logic [31:0]  ad_i = '0;
  logic [3:0]   adpar_o;
  logic [3:0]   adpar_i = '0;
  logic [4:0]   cmd_o;
  logic [4:0]   cmd_i = '0;
  logic         ad_oe, cmd_oe, cmdpar_o, cpu_req, cpu_owner, cpu_valid, ext_grant;
  logic         cmdpar_i = 1'b0, ext_req = 1'b0, ext_valid = 1'b0, ext_ready = 1'b1;

  int n_cmp = 0, n_bad = 0;
  logic [31:0]  cur_addr;
  logic [127:0] cur_dat;
  logic         cur_w, cur_blk, cur_long;
  logic [1:0]   cur_bytes;
  int           cur_n;

  always #2 clk = ~clk;

  sysbus_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_block(req_block), .req_long(req_long),
    .req_bytes(req_bytes), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .intr_valid(intr_valid), .intr_data(intr_data), .par_err(par_err),
    .par_err_data(par_err_data), .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe),
    .adpar_o(adpar_o), .adpar_i(adpar_i), .cmd_o(cmd_o), .cmd_i(cmd_i),
    .cmd_oe(cmd_oe), .cmdpar_o(cmdpar_o), .cmdpar_i(cmdpar_i),
    .cpu_req(cpu_req), .ext_req(ext_req), .cpu_owner(cpu_owner),
    .cpu_valid(cpu_valid), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .ext_grant(ext_grant)
  );

  function automatic logic [3:0] lpar(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ^d[8*k +: 8];
    return p;
  endfunction

  function automatic logic [4:0] exp_acmd();
    return {1'b0, cur_w, cur_blk, cur_blk ? {1'b0, cur_long} : cur_bytes};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(input logic w, input logic blk, input logic lng, input logic [1:0] by,
                       input logic [31:0] a, input logic [127:0] d);
    cur_w = w; cur_blk = blk; cur_long = lng; cur_bytes = by; cur_addr = a; cur_dat = d;
    cur_n = blk ? (lng ? 4 : 2) : 1;
    req_write = w; req_block = blk; req_long = lng; req_bytes = by;
    req_addr = a; req_wdata = d; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1 ready before issue", {127'b0, req_ready}, 1);
    tick();
    req_valid = 1'b0;
    chk(cpu_req == 1'b1, "R5 request pending", {127'b0, cpu_req}, 1);
  endtask

  task automatic check_addr();
    tick();
    chk(cpu_valid && cpu_owner && ad_oe && cmd_oe && ad_o == cur_addr,
        "R2 address cycle", {cpu_valid, cpu_owner, ad_oe, cmd_oe, ad_o}, {4'hf, cur_addr});
    chk(cmd_o == exp_acmd(), "R2 address command", cmd_o, exp_acmd());
    chk(adpar_o == lpar(ad_o) && cmdpar_o == ^cmd_o, "R4 address parity",
        {adpar_o, cmdpar_o}, {lpar(ad_o), ^cmd_o});
  endtask

  task automatic write_body();
    check_addr();
    for (int i = 0; i < cur_n; i++) begin
      logic [31:0] w;
      logic [4:0]  c;
      w = cur_dat[32*i +: 32];
      c = {1'b1, 2'b01, (i == cur_n - 1), 1'b0};
      tick();
      chk(ad_oe && ad_o == w && cmd_o == c, "R3 write data cycle", {ad_oe, ad_o, cmd_o}, {1'b1, w, c});
      chk(adpar_o == lpar(w) && cmdpar_o == ^c, "R4 data parity", {adpar_o, cmdpar_o}, {lpar(w), ^c});
    end
    tick();
    chk(!ad_oe && req_ready, "R10 bus released after write", {ad_oe, req_ready}, 2'b01);
  endtask

  task automatic read_body(input int bad_word, input bit bogus);
    check_addr();
    tick();
    chk(!ad_oe && !ext_grant, "R10 read turnaround", {ad_oe, ext_grant}, 0);
    tick();
    chk(ext_grant == 1'b1, "R6 grant for read data", {127'b0, ext_grant}, 1);
    if (bogus) begin
      ext_valid = 1'b1; ad_i = 32'hdead_0001; adpar_i = lpar(ad_i);
      cmd_i = 5'b10100; cmdpar_i = ^cmd_i;
      tick();
      chk(rd_valid == 1'b0, "R11 non-read cycle ignored", {127'b0, rd_valid}, 0);
    end
    for (int i = 0; i < cur_n; i++) begin
      logic [31:0] w;
      logic        lst;
      w = cur_dat[32*i +: 32];
      lst = (i == cur_n - 1);
      ext_valid = 1'b1; ad_i = w;
      adpar_i = lpar(w) ^ ((i == bad_word) ? 4'b0100 : 4'b0000);
      cmd_i = {1'b1, 2'b00, lst, 1'b0}; cmdpar_i = ^cmd_i;
      tick();
      chk(rd_valid && rd_data == w && rd_last == lst, "R6 read word",
          {rd_valid, rd_data, rd_last}, {1'b1, w, lst});
    end
    ext_valid = 1'b0;
    chk(ext_grant == 1'b0, "R6 grant dropped after last", {127'b0, ext_grant}, 0);
  endtask

  task automatic ext_body(input logic [31:0] w);
    ext_req = 1'b1;
    tick();
    chk(!ext_grant && !ad_oe, "R7 idle turnaround before grant", {ext_grant, ad_oe}, 0);
    tick();
    chk(ext_grant == 1'b1, "R7 grant to external", {127'b0, ext_grant}, 1);
    ext_req = 1'b0;
    ext_valid = 1'b1; ad_i = w; adpar_i = lpar(w); cmd_i = 5'b11010; cmdpar_i = ^cmd_i;
    tick();
    chk(intr_valid && intr_data == w, "R7 interrupt word", {intr_valid, intr_data}, {1'b1, w});
    ext_valid = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) tick();
    rst = 1'b0;
    tick();
    chk(!ad_oe && !cmd_oe && !cpu_owner && !cpu_valid && !cpu_req && !ext_grant && !par_err && req_ready,
        "R1 reset state", {ad_oe, cmd_oe, cpu_owner, cpu_valid, cpu_req, ext_grant, par_err, req_ready}, 8'h01);

    issue(1'b1, 1'b0, 1'b0, 2'd2, 32'h1000_0004, {96'h0, 32'h00a1_b2c3});
    write_body();
    issue(1'b1, 1'b1, 1'b1, 2'd0, 32'h2000_0010, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
    write_body();
    issue(1'b0, 1'b1, 1'b0, 2'd0, 32'h3000_0020, {64'h0, 64'hcafe_f00d_0bad_beef});
    read_body(-1, 1'b0);
    ext_body(32'h5a5a_0ff0);
    tick();
    chk(intr_valid == 1'b0, "R7 interrupt is a pulse", {127'b0, intr_valid}, 0);

    // R5: ready low holds the request back
    ext_ready = 1'b0;
    issue(1'b1, 1'b0, 1'b0, 2'd3, 32'h4000_0000, {96'h0, 32'h7777_8888});
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!cpu_valid && cpu_req, "R5 held while not ready", {cpu_valid, cpu_req}, 2'b01);
    end
    ext_ready = 1'b1;
    write_body();

    // R8: external request and pending processor request in one sample
    ext_ready = 1'b0;
    issue(1'b1, 1'b1, 1'b0, 2'd0, 32'h5000_0040, {64'h0, 64'h9999_aaaa_bbbb_cccc});
    tick();
    ext_ready = 1'b1;
    ext_body(32'h1234_5678);
    chk(cpu_req == 1'b1, "R8 processor still waiting after external", {127'b0, cpu_req}, 1);
    write_body();

    issue(1'b0, 1'b0, 1'b0, 2'd1, 32'h6000_0002, {96'h0, 32'h0000_abcd});
    read_body(-1, 1'b1);

    for (int it = 0; it < 40; it++) begin
      int op;
      logic [127:0] d;
      op = int'($urandom % 3);
      d = {$urandom, $urandom, $urandom, $urandom};
      if (op == 2) ext_body($urandom);
      else begin
        issue(op == 1, 1'($urandom), 1'($urandom), 2'($urandom), $urandom, d);
        if (op == 1) write_body(); else read_body(-1, 1'b0);
      end
      tick();
    end
    chk(par_err == 1'b0, "R9 no error on clean traffic", {127'b0, par_err}, 0);

    issue(1'b0, 1'b1, 1'b1, 2'd0, 32'h7000_0080, 128'h0102_0304_1111_2222_a5a5_5a5a_dddd_eeee);
    read_body(1, 1'b0);
    chk(par_err && par_err_data, "R9 parity error flagged as data", {par_err, par_err_data}, 2'b11);
    issue(1'b1, 1'b0, 1'b0, 2'd3, 32'h7000_0100, {96'h0, 32'h0f0f_0f0f});
    write_body();
    chk(par_err == 1'b1, "R9 error is sticky", {127'b0, par_err}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule